// File: doc/BRIEF.md
# Grouped Interrupt Distributor

This block collects level interrupt lines from a small set of sources and presents each of two CPU interfaces with the single best request it may take. Every source has a group bit (0 = secure, 1 = non-secure), an enable bit, an 8-bit priority and, for shared sources, a per-CPU routing mask. The control register carries a separate forwarding switch for each group, so a source reaches a CPU only when it is pending, enabled, not already in service, routed to that CPU and its group is switched on.

Sources 0 to 31 are private. Each belongs to a fixed CPU: IDs 0 to 15 go to CPU 0 and IDs 16 to 31 go to CPU 1. Sources 32 to 63 are shared and follow their routing mask. Each CPU interface acknowledges the ID it was offered. That clears the pending bit and marks the source active. A later end-of-interrupt report clears the active mark.

Software reaches the state through a word-addressed register bus. Writes take effect at the clock edge and reads are combinational. The word map is: control at 0x00 (bit 0 switches group 0 on, bit 1 switches group 1 on). Group words sit at 0x20+n and set-enable words at 0x40+n. Clear-enable words sit at 0x60+n, and in all three, bit k of word n is source 32n+k. Priority words sit at 0x80+m and routing words at 0xC0+m, and in both, byte b of word m is source 4m+b. The routing mask is held in bits 1:0 of each byte, with bit c selecting CPU c.

Top module: `grp_irq_dist`

## Requirements
- R1: After reset the control register, all group, enable and priority fields and all shared routing masks read 0, and no CPU is offered a request.
- R2: A source whose group bit is 1 is offered only while control bit 1 is set, and a source whose group bit is 0 is offered only while control bit 0 is set. Group words read back as written.
- R3: Writing a 1 to a set-enable bit sets that enable and writing a 1 to a clear-enable bit clears it, while zero bits leave the enable unchanged. Both word sets read the current enables, and a source with its enable clear is never offered.
- R4: Among the eligible sources for a CPU, the one with the numerically lowest priority is offered. A tie goes to the lowest ID.
- R5: A shared source (ID 32 or above) is offered to every CPU whose bit is set in its routing mask, and to none when the mask is 0.
- R6: A private source is offered only to its owning CPU (ID/16). Its routing byte reads back as that CPU's one-hot bit, and writes to it have no effect.
- R7: A level input high during one clock edge makes the source pending, and it stays pending after the input falls.
- R8: An acknowledge clears the source's pending bit and marks it active. An active source is offered to no CPU, even when it is pending again, until an end-of-interrupt for its ID is received.
- R9: The offer outputs are registered. A change of state at one clock edge shows on the outputs at the next edge.
- R10: With a valid offer, the ID, priority and group outputs match the offered source's current fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_lvl | input | 64 | Level interrupt inputs, one per source |
| ack_valid | input | 2 | Per-CPU acknowledge strobe |
| ack_id | input | 12 | Per-CPU acknowledged ID, 6 bits each |
| eoi_valid | input | 2 | Per-CPU end-of-interrupt strobe |
| eoi_id | input | 12 | Per-CPU completed ID, 6 bits each |
| fwd_valid | output | 2 | Per-CPU offer valid |
| fwd_id | output | 12 | Per-CPU offered ID |
| fwd_pri | output | 16 | Per-CPU offered priority |
| fwd_grp | output | 2 | Per-CPU offered group |

## Verification
The assertions assume that each interface acknowledges only the ID currently offered to it. They also assume that two interfaces never acknowledge the same ID in one cycle, and that an end-of-interrupt names only an active source and never coincides with an acknowledge of the same ID. The stimulus honours this. The bench acknowledges one CPU at a time, using the ID its own model expects, and it completes only IDs its model holds active. Levels are pulsed for single cycles, so a source never re-asserts during its own acknowledge.

// File: rtl/gid_pkg.sv
package gid_pkg;
  localparam int PRI_W = 8;
  typedef logic [PRI_W-1:0] pri_t;

  // lower value means more urgent
  function automatic logic pri_better(input pri_t a, input pri_t b);
    return a < b;
  endfunction

  // owning CPU of a private source
  function automatic int priv_owner(input int id, input int priv, input int ncpu);
    return id / (priv / ncpu);
  endfunction
endpackage

// File: rtl/gid_regs.sv
module gid_regs
  import gid_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CPU  = 2,
  parameter int PRIV_SRC = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic [1:0]                 grp_en_o,
  output logic [NUM_SRC-1:0]         src_grp_o,
  output logic [NUM_SRC-1:0]         src_en_o,
  output logic [NUM_SRC*PRI_W-1:0]   src_pri_o,
  output logic [NUM_SRC*NUM_CPU-1:0] src_tgt_o
);
  localparam int NWORD = NUM_SRC / 32;
  localparam int PWORD = NUM_SRC / 4;
  localparam int NSPI  = NUM_SRC - PRIV_SRC;
  localparam int A_CTL = 'h00;
  localparam int A_GRP = 'h20;
  localparam int A_SET = 'h40;
  localparam int A_CLR = 'h60;
  localparam int A_PRI = 'h80;
  localparam int A_TGT = 'hC0;

  logic [1:0]                grp_en_q;
  logic [NUM_SRC-1:0]        grp_q;
  logic [NUM_SRC-1:0]        en_q;
  logic [NUM_SRC*PRI_W-1:0]  pri_q;
  logic [NSPI*NUM_CPU-1:0]   spi_tgt_q;

  function automatic logic hit(input int base, input int off);
    return bus_addr == ADDR_W'(base + off);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_en_q  <= '0;
      grp_q     <= '0;
      en_q      <= '0;
      pri_q     <= '0;
      spi_tgt_q <= '0;
    end else if (bus_we) begin
      if (hit(A_CTL, 0)) grp_en_q <= bus_wdata[1:0];
      for (int w = 0; w < NWORD; w++) begin
        if (hit(A_GRP, w)) grp_q[w*32 +: 32] <= bus_wdata;
        if (hit(A_SET, w)) en_q[w*32 +: 32]  <= en_q[w*32 +: 32] | bus_wdata;
        if (hit(A_CLR, w)) en_q[w*32 +: 32]  <= en_q[w*32 +: 32] & ~bus_wdata;
      end
      for (int p = 0; p < PWORD; p++)
        if (hit(A_PRI, p)) pri_q[p*32 +: 32] <= bus_wdata;
      for (int s = PRIV_SRC; s < NUM_SRC; s++)
        if (hit(A_TGT, s / 4))
          spi_tgt_q[(s-PRIV_SRC)*NUM_CPU +: NUM_CPU] <= bus_wdata[(s%4)*8 +: NUM_CPU];
    end
  end

  // effective routing: private sources are fixed to their owner
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_tgt
    if (s < PRIV_SRC) begin : g_priv
      assign src_tgt_o[s*NUM_CPU +: NUM_CPU] =
        NUM_CPU'(1) << priv_owner(s, PRIV_SRC, NUM_CPU);
    end else begin : g_spi
      assign src_tgt_o[s*NUM_CPU +: NUM_CPU] = spi_tgt_q[(s-PRIV_SRC)*NUM_CPU +: NUM_CPU];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit(A_CTL, 0)) bus_rdata[1:0] = grp_en_q;
    for (int w = 0; w < NWORD; w++) begin
      if (hit(A_GRP, w)) bus_rdata = grp_q[w*32 +: 32];
      if (hit(A_SET, w) || hit(A_CLR, w)) bus_rdata = en_q[w*32 +: 32];
    end
    for (int p = 0; p < PWORD; p++)
      if (hit(A_PRI, p)) bus_rdata = pri_q[p*32 +: 32];
    for (int s = 0; s < NUM_SRC; s++)
      if (hit(A_TGT, s / 4)) bus_rdata[(s%4)*8 +: NUM_CPU] = src_tgt_o[s*NUM_CPU +: NUM_CPU];
  end

  assign grp_en_o  = grp_en_q;
  assign src_grp_o = grp_q;
  assign src_en_o  = en_q;
  assign src_pri_o = pri_q;
endmodule

// File: rtl/gid_state.sv
module gid_state #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC-1:0]      irq_lvl,
  input  logic [NUM_CPU-1:0]      ack_valid,
  input  logic [NUM_CPU*ID_W-1:0] ack_id,
  input  logic [NUM_CPU-1:0]      eoi_valid,
  input  logic [NUM_CPU*ID_W-1:0] eoi_id,
  output logic [NUM_SRC-1:0]      pend_o,
  output logic [NUM_SRC-1:0]      act_o,
  output logic [NUM_SRC-1:0]      ack_mask_o
);
  logic [NUM_SRC-1:0] ack_mask, eoi_mask, pend_q, act_q;

  always_comb begin
    ack_mask = '0;
    eoi_mask = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (ack_valid[c]) ack_mask[ack_id[c*ID_W +: ID_W]] = 1'b1;
      if (eoi_valid[c]) eoi_mask[eoi_id[c*ID_W +: ID_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= (pend_q | irq_lvl) & ~ack_mask;
      act_q  <= (act_q & ~eoi_mask) | ack_mask;
    end
  end

  assign pend_o     = pend_q;
  assign act_o      = act_q;
  assign ack_mask_o = ack_mask;
endmodule

// File: rtl/gid_pick.sv
module gid_pick
  import gid_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]       cand,
  input  logic [NUM_SRC*PRI_W-1:0] pri,
  output logic                     hit,
  output logic [ID_W-1:0]          id,
  output pri_t                     pri_o
);
  // ascending scan with strict compare keeps the lowest ID on ties
  always_comb begin
    hit   = 1'b0;
    id    = '0;
    pri_o = '1;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (cand[s] && (!hit || pri_better(pri[s*PRI_W +: PRI_W], pri_o))) begin
        hit   = 1'b1;
        id    = ID_W'(s);
        pri_o = pri[s*PRI_W +: PRI_W];
      end
    end
  end
endmodule

// File: rtl/grp_irq_dist.sv
module grp_irq_dist
  import gid_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CPU  = 2,
  parameter int PRIV_SRC = 32,
  parameter int ADDR_W   = 8,
  parameter int ID_W     = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [NUM_SRC-1:0]       irq_lvl,
  input  logic [NUM_CPU-1:0]       ack_valid,
  input  logic [NUM_CPU*ID_W-1:0]  ack_id,
  input  logic [NUM_CPU-1:0]       eoi_valid,
  input  logic [NUM_CPU*ID_W-1:0]  eoi_id,
  output logic [NUM_CPU-1:0]       fwd_valid,
  output logic [NUM_CPU*ID_W-1:0]  fwd_id,
  output logic [NUM_CPU*PRI_W-1:0] fwd_pri,
  output logic [NUM_CPU-1:0]       fwd_grp
);
  logic [1:0]                 ctl_grp_en;
  logic [NUM_SRC-1:0]         src_grp, src_en, src_pend, src_act, ack_mask;
  logic [NUM_SRC-1:0]         grp_ok, elig;
  logic [NUM_SRC*PRI_W-1:0]   src_pri;
  logic [NUM_SRC*NUM_CPU-1:0] src_tgt;

  gid_regs #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .PRIV_SRC(PRIV_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .grp_en_o(ctl_grp_en),
    .src_grp_o(src_grp), .src_en_o(src_en), .src_pri_o(src_pri), .src_tgt_o(src_tgt)
  );

  gid_state #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ID_W(ID_W)) u_state (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .ack_valid(ack_valid),
    .ack_id(ack_id), .eoi_valid(eoi_valid), .eoi_id(eoi_id),
    .pend_o(src_pend), .act_o(src_act), .ack_mask_o(ack_mask)
  );

  always_comb
    for (int s = 0; s < NUM_SRC; s++)
      grp_ok[s] = src_grp[s] ? ctl_grp_en[1] : ctl_grp_en[0];

  // a source being acknowledged this cycle is already out of the race
  assign elig = src_pend & ~src_act & ~ack_mask & src_en & grp_ok;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] cand;
    logic               pick_hit;
    logic [ID_W-1:0]    pick_id;
    pri_t               pick_pri;
    logic               v_q, g_q;
    logic [ID_W-1:0]    id_q;
    pri_t               pri_q;

    always_comb
      for (int s = 0; s < NUM_SRC; s++)
        cand[s] = elig[s] & src_tgt[s*NUM_CPU + c];

    gid_pick #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_pick (
      .cand(cand), .pri(src_pri), .hit(pick_hit), .id(pick_id), .pri_o(pick_pri)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q   <= 1'b0;
        id_q  <= '0;
        pri_q <= '0;
        g_q   <= 1'b0;
      end else begin
        v_q   <= pick_hit;
        id_q  <= pick_hit ? pick_id : '0;
        pri_q <= pick_hit ? pick_pri : '0;
        g_q   <= pick_hit & src_grp[pick_id];
      end
    end

    assign fwd_valid[c]               = v_q;
    assign fwd_id[c*ID_W +: ID_W]     = id_q;
    assign fwd_pri[c*PRI_W +: PRI_W]  = pri_q;
    assign fwd_grp[c]                 = g_q;
  end
endmodule

// File: rtl/grp_irq_dist_chk.sv
module grp_irq_dist_chk
  import gid_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CPU  = 2,
  parameter int PRIV_SRC = 32,
  parameter int ID_W     = $clog2(NUM_SRC)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               ctl_grp_en,
  input logic [NUM_SRC-1:0]       src_en,
  input logic [NUM_SRC-1:0]       src_act,
  input logic [NUM_SRC*PRI_W-1:0] src_pri,
  input logic [NUM_CPU-1:0]       ack_valid,
  input logic [NUM_CPU*ID_W-1:0]  ack_id,
  input logic [NUM_CPU-1:0]       fwd_valid,
  input logic [NUM_CPU*ID_W-1:0]  fwd_id,
  input logic [NUM_CPU*PRI_W-1:0] fwd_pri,
  input logic [NUM_CPU-1:0]       fwd_grp
);
  // one-cycle-old copies of the state the offer was computed from
  logic [1:0]               ctl_d;
  logic [NUM_SRC-1:0]       en_d, act_d;
  logic [NUM_SRC*PRI_W-1:0] pri_d;
  logic [NUM_CPU*ID_W-1:0]  ack_id_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_d <= '0; en_d <= '0; act_d <= '0; pri_d <= '0; ack_id_d <= '0;
    end else begin
      ctl_d <= ctl_grp_en; en_d <= src_en; act_d <= src_act; pri_d <= src_pri; ack_id_d <= ack_id;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    logic [ID_W-1:0] id_c, ack_c;
    assign id_c  = fwd_id[c*ID_W +: ID_W];
    assign ack_c = ack_id_d[c*ID_W +: ID_W];

    AST_GRP1_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid[c] && fwd_grp[c] |-> ctl_d[1]); // R2
    AST_GRP0_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid[c] && !fwd_grp[c] |-> ctl_d[0]); // R2
    AST_FWD_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid[c] |-> en_d[id_c]); // R3
    AST_PRIV_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid[c] && (int'(id_c) < PRIV_SRC) |-> priv_owner(int'(id_c), PRIV_SRC, NUM_CPU) == c); // R6
    AST_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid[c] |-> !act_d[id_c]); // R8
    AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid[c] |=> src_act[ack_c]); // R8
    AST_PRI_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid[c] |-> fwd_pri[c*PRI_W +: PRI_W] == pri_d[int'(id_c)*PRI_W +: PRI_W]); // R10
  end
endmodule

bind grp_irq_dist grp_irq_dist_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .PRIV_SRC(PRIV_SRC), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_grp_en(ctl_grp_en), .src_en(src_en),
  .src_act(src_act), .src_pri(src_pri), .ack_valid(ack_valid), .ack_id(ack_id),
  .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_pri(fwd_pri), .fwd_grp(fwd_grp)
);

// File: tb/tb_grp_irq_dist.sv
module tb_grp_irq_dist;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  logic [63:0] irq_lvl = '0;
  logic [1:0]  ack_valid = '0, eoi_valid = '0;
  logic [11:0] ack_id = '0, eoi_id = '0;
  wire  [1:0]  fwd_valid, fwd_grp;
  wire  [11:0] fwd_id;
  wire  [15:0] fwd_pri;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [1:0]  m_ctl = '0;
  logic [63:0] m_grp = '0, m_en = '0, m_pend = '0, m_act = '0;
  logic [7:0]  m_pri [64];
  logic [1:0]  m_tgt [64];

  grp_irq_dist dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lvl(irq_lvl),
    .ack_valid(ack_valid), .ack_id(ack_id), .eoi_valid(eoi_valid), .eoi_id(eoi_id),
    .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_pri(fwd_pri), .fwd_grp(fwd_grp)
  );

  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic bit routed(input int s, input int c);
    if (s < 32) return (s / 16) == c;
    return m_tgt[s][c];
  endfunction

  task automatic exp_pick(input int c, output bit hit, output int id);
    bit ok;
    hit = 0; id = 0;
    for (int s = 0; s < 64; s++) begin
      ok = m_pend[s] && !m_act[s] && m_en[s] && (m_grp[s] ? m_ctl[1] : m_ctl[0]) && routed(s, c);
      if (ok && (!hit || m_pri[s] < m_pri[id])) begin hit = 1; id = s; end
    end
  endtask

  task automatic check_fwd(input string tag);
    bit hit; int id;
    tick();
    for (int c = 0; c < 2; c++) begin
      exp_pick(c, hit, id);
      chk({tag, " valid"}, 32'(fwd_valid[c]), 32'(hit));
      if (hit) begin
        chk({tag, " id"},  32'(fwd_id[c*6 +: 6]), 32'(id));
        chk({tag, " pri"}, 32'(fwd_pri[c*8 +: 8]), 32'(m_pri[id]));
        chk({tag, " grp"}, 32'(fwd_grp[c]), 32'(m_grp[id]));
      end
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wr_ctl(input logic [31:0] d); bus_wr(8'h00, d); m_ctl = d[1:0]; endtask
  task automatic wr_grp(input int w, input logic [31:0] d); bus_wr(8'(8'h20 + w), d); m_grp[w*32 +: 32] = d; endtask
  task automatic set_en(input int w, input logic [31:0] d); bus_wr(8'(8'h40 + w), d); m_en[w*32 +: 32] |= d; endtask
  task automatic clr_en(input int w, input logic [31:0] d); bus_wr(8'(8'h60 + w), d); m_en[w*32 +: 32] &= ~d; endtask
  task automatic wr_pri(input int p, input logic [31:0] d);
    bus_wr(8'(8'h80 + p), d);
    for (int b = 0; b < 4; b++) m_pri[p*4+b] = d[b*8 +: 8];
  endtask
  task automatic wr_tgt(input int p, input logic [31:0] d);
    bus_wr(8'(8'hC0 + p), d);
    for (int b = 0; b < 4; b++) if (p*4 + b >= 32) m_tgt[p*4+b] = d[b*8 +: 2];
  endtask

  task automatic pulse(input logic [63:0] v);
    irq_lvl = v; tick(); irq_lvl = '0;
    m_pend |= v;
  endtask

  task automatic do_ack(input int c, input int id);
    ack_valid[c] = 1; ack_id[c*6 +: 6] = 6'(id);
    tick();
    ack_valid = '0;
    m_pend[id] = 0; m_act[id] = 1;
  endtask

  task automatic do_eoi(input int c, input int id);
    eoi_valid[c] = 1; eoi_id[c*6 +: 6] = 6'(id);
    tick();
    eoi_valid = '0;
    m_act[id] = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit hit; int id;
    void'($urandom(32'd20240611));
    for (int s = 0; s < 64; s++) begin m_pri[s] = '0; m_tgt[s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();

    // R1: reset state
    rd_chk("R1 ctrl", 8'h00, 32'h0);
    rd_chk("R1 grp0", 8'h20, 32'h0);
    rd_chk("R1 grp1", 8'h21, 32'h0);
    rd_chk("R1 en1", 8'h41, 32'h0);
    rd_chk("R1 pri", 8'h8F, 32'h0);
    rd_chk("R1 spi tgt", 8'hC8, 32'h0);
    chk("R1 no offer", 32'(fwd_valid), 32'h0);
    // R6: private routing reads as owner bit
    rd_chk("R6 tgt cpu0", 8'hC0, 32'h01010101);
    rd_chk("R6 tgt cpu1", 8'hC4, 32'h02020202);

    // R3: W1S / W1C enables
    set_en(0, 32'h5); set_en(0, 32'hA);
    rd_chk("R3 set read", 8'h40, 32'hF);
    rd_chk("R3 clr read", 8'h60, 32'hF);
    clr_en(0, 32'h3);
    rd_chk("R3 after clr", 8'h40, 32'hC);
    clr_en(0, 32'hFFFF_FFFF);

    // R2: group gating, source 40 group 1 to CPU0
    wr_pri(10, 32'h0000_0010);
    wr_tgt(10, 32'h0000_0001);
    wr_grp(1, 32'h0000_0100);
    rd_chk("R2 grp read", 8'h21, 32'h100);
    set_en(1, 32'h0000_0100);
    wr_ctl(32'h1);
    pulse(64'h1 << 40);
    check_fwd("R2 grp1 off");
    chk("R2 grp1 blocked", 32'(fwd_valid[0]), 32'h0);
    wr_ctl(32'h2);
    check_fwd("R2 grp1 on");
    chk("R2 grp1 offered", 32'(fwd_id[5:0]), 32'd40);
    wr_ctl(32'h3);

    // R4: tie -> lowest id, then lower value wins (CPU1, group 0)
    wr_pri(11, 32'h0003_0505);
    wr_tgt(11, 32'h0202_0202);
    set_en(1, 32'h0000_7000);
    pulse((64'h1 << 44) | (64'h1 << 45));
    check_fwd("R4 tie");
    chk("R4 tie lowest id", 32'(fwd_id[11:6]), 32'd44);
    pulse(64'h1 << 46);
    check_fwd("R4 lower value");
    chk("R4 lower value wins", 32'(fwd_id[11:6]), 32'd46);

    // R6: private routing write ignored; R9 latency; R7 pending held
    wr_tgt(1, 32'h0202_0202);
    rd_chk("R6 write ignored", 8'hC1, 32'h01010101);
    wr_pri(1, 32'h0000_0900);
    set_en(0, 32'h20);
    irq_lvl = 64'h1 << 5; tick(); irq_lvl = '0; m_pend[5] = 1;
    chk("R9 not yet", 32'(fwd_id[5:0]), 32'd40);
    check_fwd("R7 held after drop");
    chk("R7 source 5 offered", 32'(fwd_id[5:0]), 32'd5);
    chk("R6 not on cpu1", 32'(fwd_id[11:6]), 32'd46);

    // R8: ack, re-pend while active, eoi
    do_ack(0, 5);
    chk("R8 ack moves on", 32'(fwd_id[5:0]), 32'd40);
    pulse(64'h1 << 5);
    check_fwd("R8 active blocked");
    chk("R8 still blocked", 32'(fwd_id[5:0]), 32'd40);
    do_eoi(0, 5);
    check_fwd("R8 after eoi");
    chk("R8 re-offered", 32'(fwd_id[5:0]), 32'd5);

    // R5: shared source to both CPUs, mask 0 to none
    wr_pri(11, 32'h0003_0505);
    bus_wr(8'h8B, 32'h0003_0505); // keep; 47 gets set below
    wr_pri(11, 32'h0003_0505 & 32'h00FF_FFFF);
    wr_tgt(11, 32'h0302_0202);
    set_en(1, 32'h0000_8000);
    pulse(64'h1 << 47);
    check_fwd("R5 both");
    chk("R5 cpu0 sees 47", 32'(fwd_id[5:0]), 32'd47);
    chk("R5 cpu1 sees 47", 32'(fwd_id[11:6]), 32'd47);
    do_ack(0, 47);
    check_fwd("R5 after ack");
    wr_tgt(12, 32'h0);
    wr_pri(12, 32'h0);
    set_en(1, 32'h0001_0000);
    pulse(64'h1 << 48);
    check_fwd("R5 mask zero");
    do_eoi(0, 47);
    check_fwd("R5 eoi");

    // random phase, R2 R3 R4 R5 R8 R10
    for (int it = 0; it < 400; it++) begin
      int op; op = $urandom % 9;
      case (op)
        0: wr_pri($urandom % 16, $urandom & 32'h0303_0303);
        1: wr_grp($urandom % 2, $urandom);
        2: set_en($urandom % 2, $urandom);
        3: clr_en($urandom % 2, $urandom & $urandom);
        4: wr_tgt(8 + $urandom % 8, $urandom & 32'h0303_0303);
        5: wr_ctl($urandom % 4);
        6: pulse({$urandom, $urandom} & {$urandom, $urandom});
        7: begin
             int c; c = $urandom % 2;
             exp_pick(c, hit, id);
             if (hit) do_ack(c, id);
           end
        default: begin
             int st; st = $urandom % 64;
             for (int k = 0; k < 64; k++)
               if (m_act[(st + k) % 64]) begin do_eoi($urandom % 2, (st + k) % 64); break; end
           end
      endcase
      check_fwd("R4 R10 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule